// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block keeps the per-channel transfer state of a simple DMA controller. It holds a source address, a destination address and a byte counter, together with three shadow reload values. On every accepted bus beat it moves each enabled address forward by the beat width and subtracts the beat width from the counter. When the counter reaches zero it raises a one-cycle terminal pulse.

At that same point the channel either reloads all three working values from their shadows, so that another block of data follows with no gap, or it stops and holds a sticky completion flag. Software sees the six values through a small write/read port. The transfer logic supplies the beat strobe, the beat width, the increment enables, the reload enable and the endpoint-type flags.

Top module: `dma_chan_addr_engine`

## Requirements
- R1: After reset, every working value and every reload value is zero, and `ctz` and `done` are both low.
- R2: The counter register (index 2) keeps only its low CNT_W (24) bits. Higher write bits are dropped, and those bits read back as zero.
- R3: An accepted beat subtracts the beat width in bytes from the counter. `beat_width` 2'b00 gives 1, 2'b01 gives 2, and both 2'b10 and 2'b11 give 4.
- R4: On an accepted beat, each address whose increment enable is high advances by the beat width and wraps modulo 2^32. An address whose enable is low holds its value.
- R5: When an accepted beat finds a remaining count less than or equal to the beat width, the counter goes to zero without underflow. `ctz` is then high for exactly the one cycle after that clock edge.
- R6: If `rld_en` is high on the terminal beat, the source, destination and counter take their reload values (indices 3, 4, 5) on that same edge. The next beat then works from the reloaded values, and `done` stays low.
- R7: The source and destination reload registers (indices 3 and 4) keep 31 bits. Bit 31 is dropped on write and reads back as zero.
- R8: If `rld_en` is low on the terminal beat, `done` rises and stays high. While it is high, beats change neither the counter nor the addresses. Writing a nonzero count clears `done`; writing zero does not.
- R9: When an endpoint's peripheral flag is high, its address output reads zero. Its stored register value, as read back through the register port, is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index: 0 src, 1 dst, 2 count, 3 src reload, 4 dst reload, 5 count reload |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_idx` (combinational; zero for unused indices) |
| beat | input | 1 | One bus beat transferred this cycle |
| beat_width | input | 2 | Beat width code |
| src_inc | input | 1 | Source increment enable |
| dst_inc | input | 1 | Destination increment enable |
| src_periph | input | 1 | Source is a peripheral endpoint |
| dst_periph | input | 1 | Destination is a peripheral endpoint |
| rld_en | input | 1 | Reload on terminal count |
| src_addr | output | 32 | Current source address as presented |
| dst_addr | output | 32 | Current destination address as presented |
| count | output | 24 | Remaining byte count |
| ctz | output | 1 | Terminal-count pulse |
| done | output | 1 | Sticky completion flag |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 24-bit counter and 31-bit address shadows. With these values a single write reaches the dropped upper count bits and the reserved bit 31 of each shadow. A source address placed near the top of the 32-bit space makes the modulo wrap happen in one word beat. Small counts of 2 and 3 bytes, combined with halfword and word beats, reach the saturating terminal case both with and without reload.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        BW_BYTE = 2'b00,
        BW_HALF = 2'b01,
        BW_WORD = 2'b10,
        BW_WALT = 2'b11
    } beat_width_e;

    localparam logic [2:0] IDX_SRC     = 3'd0;
    localparam logic [2:0] IDX_DST     = 3'd1;
    localparam logic [2:0] IDX_CNT     = 3'd2;
    localparam logic [2:0] IDX_SRC_RLD = 3'd3;
    localparam logic [2:0] IDX_DST_RLD = 3'd4;
    localparam logic [2:0] IDX_CNT_RLD = 3'd5;

    function automatic logic [2:0] width_bytes(input logic [1:0] code);
        case (beat_width_e'(code))
            BW_BYTE: width_bytes = 3'd1;
            BW_HALF: width_bytes = 3'd2;
            default: width_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
    parameter int ADDR_W = 32,
    parameter int RLD_W  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_work,
    input  logic              wr_rld,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              advance,
    input  logic              reload,
    input  logic              inc_en,
    input  logic              periph,
    input  logic [2:0]        step,
    output logic [ADDR_W-1:0] addr_out,
    output logic [ADDR_W-1:0] work_val,
    output logic [ADDR_W-1:0] rld_val
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [RLD_W-1:0]  rld;
    } addr_state_t;

    addr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reload) begin
            st_d.addr = ADDR_W'(st_q.rld);
        end else if (advance && inc_en) begin
            st_d.addr = st_q.addr + ADDR_W'(step);
        end
        if (wr_work) st_d.addr = wdata;
        if (wr_rld)  st_d.rld  = wdata[RLD_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_out = periph ? '0 : st_q.addr;
    assign work_val = st_q.addr;
    assign rld_val  = ADDR_W'(st_q.rld);
endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cnt,
    input  logic             wr_rld,
    input  logic [CNT_W-1:0] wdata,
    input  logic             beat,
    input  logic [2:0]       step,
    input  logic             rld_en,
    output logic             accept,
    output logic             reload,
    output logic [CNT_W-1:0] cnt_val,
    output logic [CNT_W-1:0] cnt_rld_val,
    output logic             ctz,
    output logic             done
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic             ctz;
        logic             done;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] step_ext;
    logic             last;

    assign step_ext = CNT_W'(step);
    assign accept   = beat && (st_q.cnt != '0) && !st_q.done;
    assign last     = st_q.cnt <= step_ext;
    assign reload   = accept && last && rld_en;

    always_comb begin
        st_d     = st_q;
        st_d.ctz = 1'b0;
        if (accept) begin
            if (last) begin
                st_d.ctz = 1'b1;
                if (rld_en) begin
                    st_d.cnt = st_q.rld;
                end else begin
                    st_d.cnt  = '0;
                    st_d.done = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt - step_ext;
            end
        end
        if (wr_rld) st_d.rld = wdata;
        if (wr_cnt) begin
            st_d.cnt = wdata;
            if (wdata != '0) st_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_val     = st_q.cnt;
    assign cnt_rld_val = st_q.rld;
    assign ctz         = st_q.ctz;
    assign done        = st_q.done;
endmodule

// File: rtl/dma_chan_addr_engine.sv
module dma_chan_addr_engine
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24,
    parameter int RLD_W  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_idx,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              beat,
    input  logic [1:0]        beat_width,
    input  logic              src_inc,
    input  logic              dst_inc,
    input  logic              src_periph,
    input  logic              dst_periph,
    input  logic              rld_en,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  count,
    output logic              ctz,
    output logic              done
);
    localparam int N_EP = 2;

    logic [2:0]        step;
    logic              accept, reload;
    logic [CNT_W-1:0]  cnt_val, cnt_rld_val;
    logic [N_EP-1:0]   ep_wr_work, ep_wr_rld, ep_inc, ep_periph;
    logic [ADDR_W-1:0] ep_out  [N_EP];
    logic [ADDR_W-1:0] ep_work [N_EP];
    logic [ADDR_W-1:0] ep_rld  [N_EP];

    assign step = width_bytes(beat_width);

    assign ep_wr_work = {reg_wr && reg_idx == IDX_DST,     reg_wr && reg_idx == IDX_SRC};
    assign ep_wr_rld  = {reg_wr && reg_idx == IDX_DST_RLD, reg_wr && reg_idx == IDX_SRC_RLD};
    assign ep_inc     = {dst_inc, src_inc};
    assign ep_periph  = {dst_periph, src_periph};

    for (genvar e = 0; e < N_EP; e++) begin : g_ep
        dma_addr_unit #(.ADDR_W(ADDR_W), .RLD_W(RLD_W)) u_addr (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_work  (ep_wr_work[e]),
            .wr_rld   (ep_wr_rld[e]),
            .wdata    (reg_wdata),
            .advance  (accept),
            .reload   (reload),
            .inc_en   (ep_inc[e]),
            .periph   (ep_periph[e]),
            .step     (step),
            .addr_out (ep_out[e]),
            .work_val (ep_work[e]),
            .rld_val  (ep_rld[e])
        );
    end

    dma_count_unit #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_cnt      (reg_wr && reg_idx == IDX_CNT),
        .wr_rld      (reg_wr && reg_idx == IDX_CNT_RLD),
        .wdata       (reg_wdata[CNT_W-1:0]),
        .beat        (beat),
        .step        (step),
        .rld_en      (rld_en),
        .accept      (accept),
        .reload      (reload),
        .cnt_val     (cnt_val),
        .cnt_rld_val (cnt_rld_val),
        .ctz         (ctz),
        .done        (done)
    );

    always_comb begin
        case (reg_idx)
            IDX_SRC:     reg_rdata = ep_work[0];
            IDX_DST:     reg_rdata = ep_work[1];
            IDX_CNT:     reg_rdata = ADDR_W'(cnt_val);
            IDX_SRC_RLD: reg_rdata = ep_rld[0];
            IDX_DST_RLD: reg_rdata = ep_rld[1];
            IDX_CNT_RLD: reg_rdata = ADDR_W'(cnt_rld_val);
            default:     reg_rdata = '0;
        endcase
    end

    assign src_addr = ep_out[0];
    assign dst_addr = ep_out[1];
    assign count    = cnt_val;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_idx,
    input logic [ADDR_W-1:0] reg_rdata,
    input logic              beat,
    input logic              rld_en,
    input logic              dst_periph,
    input logic [ADDR_W-1:0] dst_addr,
    input logic [CNT_W-1:0]  count,
    input logic              ctz,
    input logic              done
);
    // R2
    cnt_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_idx == 3'd2 |-> reg_rdata[ADDR_W-1:CNT_W] == '0);

    // R3
    cnt_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !done && !reg_wr && count > CNT_W'(4)) |=> (count < $past(count)) && !ctz);

    // R5
    ctz_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctz |-> ($past(beat) && $past(count) != '0));

    // R7
    rld_bit31_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == 3'd3 || reg_idx == 3'd4) |-> reg_rdata[ADDR_W-1] == 1'b0);

    // R8
    done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> count == '0);

    // R8
    stop_on_ctz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctz && !$past(rld_en)) |-> done);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !reg_wr) |=> $stable(count) && !ctz);

    // R9
    periph_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_periph |-> dst_addr == '0);
endmodule

bind dma_chan_addr_engine dma_chan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_idx    (reg_idx),
    .reg_rdata  (reg_rdata),
    .beat       (beat),
    .rld_en     (rld_en),
    .dst_periph (dst_periph),
    .dst_addr   (dst_addr),
    .count      (count),
    .ctz        (ctz),
    .done       (done)
);

// File: tb/test_dma_chan_addr_engine.sv
module test_dma_chan_addr_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        beat = 1'b0;
    logic [1:0]  beat_width = '0;
    logic        src_inc = 1'b0, dst_inc = 1'b0;
    logic        src_periph = 1'b0, dst_periph = 1'b0;
    logic        rld_en = 1'b0;
    logic [31:0] src_addr, dst_addr;
    logic [23:0] count;
    logic        ctz, done;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dma_chan_addr_engine i_dma_chan_addr_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .beat(beat),
        .beat_width(beat_width), .src_inc(src_inc), .dst_inc(dst_inc),
        .src_periph(src_periph), .dst_periph(dst_periph), .rld_en(rld_en),
        .src_addr(src_addr), .dst_addr(dst_addr), .count(count),
        .ctz(ctz), .done(done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] data);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] data);
        reg_idx = idx;
        #1;
        data = reg_rdata;
    endtask

    task automatic one_beat(input logic [1:0] w);
        beat = 1'b1; beat_width = w;
        @(negedge clk);
        beat = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 src", src_addr, 0);
        check("R1 dst", dst_addr, 0);
        check("R1 count", 32'(count), 0);
        check("R1 ctz/done", {30'd0, ctz, done}, 0);
        for (int i = 3; i < 6; i++) begin
            rd(3'(i), v);
            check("R1 reload", v, 0);
        end
    endtask

    task automatic t_count_mask();
        logic [31:0] v;
        wr(3'd2, 32'hAB12_3456);
        rd(3'd2, v);
        check("R2 count mask", v, 32'h0012_3456);
    endtask

    task automatic t_step_widths();
        wr(3'd0, 32'h1000); wr(3'd1, 32'h2000); wr(3'd2, 100);
        src_inc = 1'b1; dst_inc = 1'b0;
        one_beat(2'b00);
        check("R3 byte", 32'(count), 99);
        check("R4 src byte", src_addr, 32'h1001);
        check("R4 dst hold", dst_addr, 32'h2000);
        one_beat(2'b01);
        check("R3 half", 32'(count), 97);
        check("R4 src half", src_addr, 32'h1003);
        one_beat(2'b10);
        check("R3 word", 32'(count), 93);
        check("R4 src word", src_addr, 32'h1007);
        one_beat(2'b11);
        check("R3 code 11", 32'(count), 89);
        check("R4 src code 11", src_addr, 32'h100B);
        check("R5 no ctz mid", {31'd0, ctz}, 0);
    endtask

    task automatic t_wrap();
        wr(3'd0, 32'hFFFF_FFFE);
        one_beat(2'b10);
        check("R4 wrap", src_addr, 32'h0000_0002);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        rld_en = 1'b0; src_inc = 1'b1;
        wr(3'd0, 32'h500); wr(3'd2, 3);
        one_beat(2'b10);
        check("R5 saturate", 32'(count), 0);
        check("R5 ctz high", {31'd0, ctz}, 1);
        check("R8 done set", {31'd0, done}, 1);
        @(negedge clk);
        check("R5 ctz one cycle", {31'd0, ctz}, 0);
        one_beat(2'b00);
        check("R8 beat ignored src", src_addr, 32'h504);
        check("R8 beat ignored cnt", 32'(count), 0);
        wr(3'd2, 0);
        check("R8 zero keeps done", {31'd0, done}, 1);
        wr(3'd2, 8);
        check("R8 nonzero clears", {31'd0, done}, 0);
        rd(3'd2, v);
        check("R8 count loaded", v, 8);
    endtask

    task automatic t_reload();
        logic [31:0] v;
        wr(3'd3, 32'hFFFF_0010);
        rd(3'd3, v);
        check("R7 src rld bit31", v, 32'h7FFF_0010);
        wr(3'd4, 32'h8000_0020);
        rd(3'd4, v);
        check("R7 dst rld bit31", v, 32'h0000_0020);
        wr(3'd5, 6);
        wr(3'd0, 32'h100); wr(3'd1, 32'h200); wr(3'd2, 2);
        rld_en = 1'b1; src_inc = 1'b1; dst_inc = 1'b1;
        one_beat(2'b01);
        check("R6 ctz", {31'd0, ctz}, 1);
        check("R6 src", src_addr, 32'h7FFF_0010);
        check("R6 dst", dst_addr, 32'h20);
        check("R6 count", 32'(count), 6);
        check("R6 done low", {31'd0, done}, 0);
        one_beat(2'b00);
        check("R6 next beat cnt", 32'(count), 5);
        check("R6 next beat src", src_addr, 32'h7FFF_0011);
        rld_en = 1'b0;
    endtask

    task automatic t_periph();
        logic [31:0] v;
        wr(3'd1, 32'h3000);
        dst_periph = 1'b1;
        #1;
        check("R9 dst out zero", dst_addr, 0);
        rd(3'd1, v);
        check("R9 dst readback", v, 32'h3000);
        dst_periph = 1'b0;
        #1;
        check("R9 dst restored", dst_addr, 32'h3000);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_count_mask();
                t_step_widths();
                t_wrap();
                t_stop();
                t_reload();
                t_periph();
            end
            begin
                repeat (5000) @(negedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule